// File: doc/BRIEF.md
# DDR Controller Write-Request Adapter

This block sits between a simple user write port and the two input queues of a DDR SDRAM controller's user interface: a command queue and a write-data queue. A user presents one write request at a time, made of bank, row and column numbers, a full burst of write data and one write-enable bit per data byte. The adapter packs the address fields into the controller's fixed-width command word. It pushes the burst into the data queue as double-width beats, each with its byte mask, and then pushes a single write command.

A beat is twice the width of the external DDR data bus, so a burst of length BL takes BL/2 beats. Requests whose column is not aligned to a burst boundary are refused with a one-cycle error pulse. Both queues can apply backpressure: the data queue through an almost-full flag and the command queue through a full flag. The user port stays not-ready until the whole burst and its command are queued.

Top module: `ddr_wr_adapter`

## Requirements
- R1: The command word is 31 bits. The column number occupies bits [COL_W-1:0], the row number the next ROW_W bits above it, and the bank number the BANK_W bits above the row.
- R2: Command word bits at and above BANK_W+ROW_W+COL_W are always 0.
- R3: A request is accepted in a cycle where req_valid and req_ready are both 1. If the low log2(BL) bits of req_col are not all 0, the adapter pulses req_err for one cycle in the following cycle, pushes no beat and no command, and keeps req_ready at 1.
- R4: An aligned request produces exactly BL/2 data-queue pushes followed by one command push. Beat k carries req_data[k*2*DQ_W +: 2*DQ_W], starting with k = 0.
- R5: Every beat of a burst is pushed in an earlier cycle than the command that belongs to it.
- R6: With MASK_EN = 1, wd_mask bit j of beat k equals the inverse of req_be[k*BYTES + j]. A mask bit of 1 suppresses that byte.
- R7: With MASK_EN = 0, wd_mask is all zeros on every beat.
- R8: No beat is pushed in the cycle after a cycle with wd_afull = 1. No command is pushed in the cycle after a cycle with cmd_full = 1.
- R9: req_ready is 0 from the cycle after acceptance of an aligned request up to the cycle in which its command is pushed.
- R10: Under reset, req_ready is 1 and wd_valid, cmd_valid and req_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | User request present |
| req_ready | output | 1 | Adapter can take a request |
| req_bank | input | BANK_W | Bank number |
| req_row | input | ROW_W | Row number |
| req_col | input | COL_W | Column number, burst aligned |
| req_data | input | BL*DQ_W | Whole burst, beat 0 in the low bits |
| req_be | input | BL*DQ_W/8 | Byte write enables, 1 = write |
| req_err | output | 1 | One-cycle pulse: misaligned request refused |
| cmd_valid | output | 1 | Command queue push |
| cmd_addr | output | 31 | Packed command address |
| cmd_full | input | 1 | Command queue full |
| wd_valid | output | 1 | Data queue push |
| wd_data | output | 2*DQ_W | Beat data |
| wd_mask | output | 2*DQ_W/8 | Byte mask, 1 = skip |
| wd_afull | input | 1 | Data queue almost full |

## Verification
On every cycle, the assertions check the backpressure rules and the zeroed upper command bits. They also check that each command carries an aligned column and that exactly BL/2 beats come before it. They also check that the user port stays closed while beats are being pushed, and that masks stay zero when masking is off. Only the bench scenarios can show that the right bank, row and column land in the right fields and that beats arrive in order with the right data. They also show that each mask is the inverse of its enables and that misaligned requests produce an error and nothing else. The bench runs under random stall patterns and uses a second instance with masking off.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;
  localparam int CMD_ADDR_W = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CMD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ddr_addr_pack.sv
module ddr_addr_pack #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BL     = 4
) (
  input  logic [BANK_W-1:0]                  bank,
  input  logic [ROW_W-1:0]                   row,
  input  logic [COL_W-1:0]                   col,
  output logic [ddr_wr_pkg::CMD_ADDR_W-1:0]  addr,
  output logic                               aligned
);
  localparam int USED  = BANK_W + ROW_W + COL_W;
  localparam int ALIGN = $clog2(BL);

  // column lowest, row above, bank on top; rest forced to zero
  always_comb begin
    addr = '0;
    addr[USED-1:0] = {bank, row, col};
  end

  assign aligned = (col[ALIGN-1:0] == '0);
endmodule

// File: rtl/ddr_mask_gen.sv
module ddr_mask_gen #(
  parameter int N       = 8,
  parameter bit MASK_EN = 1'b1
) (
  input  logic [N-1:0] be,
  output logic [N-1:0] mask
);
  generate
    if (MASK_EN) begin : g_inv
      assign mask = ~be;
    end else begin : g_off
      logic unused_be;
      assign unused_be = ^be;
      assign mask = '0;
    end
  endgenerate
endmodule

// File: rtl/ddr_beat_seq.sv
module ddr_beat_seq #(
  parameter int WDW   = 32,
  parameter int BYTES = 4,
  parameter int BEATS = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              aligned,
  input  logic [BEATS*WDW-1:0]              in_data,
  input  logic [BEATS*BYTES-1:0]            in_mask,
  input  logic [ddr_wr_pkg::CMD_ADDR_W-1:0] in_addr,
  output logic                              req_err,
  input  logic                              wd_afull,
  output logic                              wd_valid,
  output logic [WDW-1:0]                    wd_data,
  output logic [BYTES-1:0]                  wd_mask,
  input  logic                              cmd_full,
  output logic                              cmd_valid,
  output logic [ddr_wr_pkg::CMD_ADDR_W-1:0] cmd_addr
);
  import ddr_wr_pkg::*;

  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS - 1);

  seq_state_e state;
  logic [IDX_W-1:0]          idx;
  logic [BEATS*WDW-1:0]      data_buf;
  logic [BEATS*BYTES-1:0]    mask_buf;
  logic [CMD_ADDR_W-1:0]     addr_buf;
  logic                      take;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready && aligned;

  // burst holding registers: no reset, plain load enable
  always_ff @(posedge clk) begin
    if (take) begin
      data_buf <= in_data;
      mask_buf <= in_mask;
      addr_buf <= in_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      req_err   <= 1'b0;
      wd_valid  <= 1'b0;
      wd_data   <= '0;
      wd_mask   <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
    end else begin
      req_err   <= 1'b0;
      wd_valid  <= 1'b0;
      cmd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (aligned) begin
              idx   <= '0;
              state <= ST_DATA;
            end else begin
              req_err <= 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (!wd_afull) begin
            wd_valid <= 1'b1;
            wd_data  <= data_buf[int'(idx)*WDW +: WDW];
            wd_mask  <= mask_buf[int'(idx)*BYTES +: BYTES];
            idx      <= idx + 1'b1;
            if (idx == LAST) state <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (!cmd_full) begin
            cmd_valid <= 1'b1;
            cmd_addr  <= addr_buf;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_wr_adapter.sv
module ddr_wr_adapter #(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int DQ_W    = 16,
  parameter int BL      = 4,
  parameter bit MASK_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [BANK_W-1:0]         req_bank,
  input  logic [ROW_W-1:0]          req_row,
  input  logic [COL_W-1:0]          req_col,
  input  logic [BL*DQ_W-1:0]        req_data,
  input  logic [BL*DQ_W/8-1:0]      req_be,
  output logic                      req_err,
  output logic                      cmd_valid,
  output logic [30:0]               cmd_addr,
  input  logic                      cmd_full,
  output logic                      wd_valid,
  output logic [2*DQ_W-1:0]         wd_data,
  output logic [2*DQ_W/8-1:0]       wd_mask,
  input  logic                      wd_afull
);
  import ddr_wr_pkg::*;

  localparam int WDW   = 2 * DQ_W;
  localparam int BYTES = WDW / 8;
  localparam int BEATS = BL / 2;

  generate
    if (BANK_W + ROW_W + COL_W > CMD_ADDR_W) begin : g_bad_width
      $error("bank+row+column widths exceed the command word");
    end
    if (BL != 4 && BL != 8) begin : g_bad_bl
      $error("burst length must be 4 or 8");
    end
  endgenerate

  logic [CMD_ADDR_W-1:0]  packed_addr;
  logic                   aligned;
  logic [BEATS*BYTES-1:0] mask_all;

  ddr_addr_pack #(
    .BANK_W (BANK_W), .ROW_W (ROW_W), .COL_W (COL_W), .BL (BL)
  ) u_pack (
    .bank    (req_bank),
    .row     (req_row),
    .col     (req_col),
    .addr    (packed_addr),
    .aligned (aligned)
  );

  ddr_mask_gen #(
    .N (BEATS*BYTES), .MASK_EN (MASK_EN)
  ) u_mask (
    .be   (req_be),
    .mask (mask_all)
  );

  ddr_beat_seq #(
    .WDW (WDW), .BYTES (BYTES), .BEATS (BEATS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .aligned   (aligned),
    .in_data   (req_data),
    .in_mask   (mask_all),
    .in_addr   (packed_addr),
    .req_err   (req_err),
    .wd_afull  (wd_afull),
    .wd_valid  (wd_valid),
    .wd_data   (wd_data),
    .wd_mask   (wd_mask),
    .cmd_full  (cmd_full),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr)
  );
endmodule

// File: rtl/ddr_wr_adapter_chk.sv
module ddr_wr_adapter_chk #(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int DQ_W    = 16,
  parameter int BL      = 4,
  parameter bit MASK_EN = 1'b1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_err,
  input logic                  wd_valid,
  input logic [2*DQ_W/8-1:0]   wd_mask,
  input logic                  wd_afull,
  input logic                  cmd_valid,
  input logic [30:0]           cmd_addr,
  input logic                  cmd_full
);
  localparam int USED  = BANK_W + ROW_W + COL_W;
  localparam int ALIGN = $clog2(BL);
  localparam int BEATS = BL / 2;

  logic [7:0] beat_cnt;
  always_ff @(posedge clk) begin
    if (rst)            beat_cnt <= '0;
    else if (cmd_valid) beat_cnt <= '0;
    else if (wd_valid)  beat_cnt <= beat_cnt + 8'd1;
  end

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ((cmd_addr >> USED) == 31'd0));

  p_cmd_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_addr[ALIGN-1:0] == '0));

  p_err_silent_r3: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (!wd_valid && !cmd_valid && req_ready));

  // R5 too: the beats are counted before the command arrives
  p_beat_count_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (beat_cnt == 8'(BEATS)));

  p_no_push_afull_r8: assert property (@(posedge clk) disable iff (rst)
    wd_valid |-> !$past(wd_afull));

  p_no_cmd_full_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !$past(cmd_full));

  p_closed_busy_r9: assert property (@(posedge clk) disable iff (rst)
    wd_valid |-> !req_ready);

  generate
    if (!MASK_EN) begin : g_nomask
      p_mask_off_r7: assert property (@(posedge clk) disable iff (rst)
        wd_valid |-> (wd_mask == '0));
    end
  endgenerate

  logic unused_rv;
  assign unused_rv = req_valid;
endmodule

bind ddr_wr_adapter ddr_wr_adapter_chk #(
  .BANK_W (BANK_W), .ROW_W (ROW_W), .COL_W (COL_W),
  .DQ_W (DQ_W), .BL (BL), .MASK_EN (MASK_EN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_err   (req_err),
  .wd_valid  (wd_valid),
  .wd_mask   (wd_mask),
  .wd_afull  (wd_afull),
  .cmd_valid (cmd_valid),
  .cmd_addr  (cmd_addr),
  .cmd_full  (cmd_full)
);

// File: tb/sim_ddr_wr_adapter.sv
`timescale 1ns/1ps
module sim_ddr_wr_adapter;
  localparam int BANK_W = 2, ROW_W = 13, COL_W = 10, DQ_W = 16, BL = 4;
  localparam int WDW = 2*DQ_W, BYTES = WDW/8, BEATS = BL/2;
  localparam int USED = BANK_W + ROW_W + COL_W, ALIGN = $clog2(BL);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [BL*DQ_W-1:0] req_data = '0;
  logic [BL*DQ_W/8-1:0] req_be = '0;
  logic cmd_full = 1'b0, wd_afull = 1'b0;

  logic req_ready, req_err, cmd_valid, wd_valid;
  logic [30:0] cmd_addr;
  logic [WDW-1:0] wd_data;
  logic [BYTES-1:0] wd_mask;
  logic r1_ready, r1_err, r1_cv, r1_wv;
  logic [30:0] r1_addr;
  logic [WDW-1:0] r1_data;
  logic [BYTES-1:0] r1_mask;

  ddr_wr_adapter #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .BL(BL), .MASK_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_data(req_data), .req_be(req_be), .req_err(req_err),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_full(cmd_full), .wd_valid(wd_valid),
    .wd_data(wd_data), .wd_mask(wd_mask), .wd_afull(wd_afull));

  ddr_wr_adapter #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .BL(BL), .MASK_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(r1_ready), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_data(req_data), .req_be(req_be), .req_err(r1_err),
    .cmd_valid(r1_cv), .cmd_addr(r1_addr), .cmd_full(cmd_full), .wd_valid(r1_wv),
    .wd_data(r1_data), .wd_mask(r1_mask), .wd_afull(wd_afull));

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  bit busy = 1'b0;
  int beats_seen = 0;
  int stall_pct = 0;
  logic afull_prev = 1'b0, full_prev = 1'b0;
  logic [WDW-1:0] qd[$];
  logic [BYTES-1:0] qm[$];
  logic [30:0] qa[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [30:0] pack(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r,
                                       input logic [COL_W-1:0] c);
    return 31'({b, r, c});
  endfunction

  // output monitor and stall generator, all on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (wd_valid) begin
        chk(!afull_prev, "R8 beat after afull", 64'(wd_valid), 64'd0);
        if (qd.size() == 0) chk(1'b0, "R4 unexpected beat", 64'(wd_data), 64'd0);
        else begin
          logic [WDW-1:0] ed;
          logic [BYTES-1:0] em;
          ed = qd.pop_front();
          em = qm.pop_front();
          chk(wd_data == ed, "R4 beat data", 64'(wd_data), 64'(ed));
          chk(wd_mask == em, "R6 mask", 64'(wd_mask), 64'(em));
        end
        beats_seen++;
      end
      if (r1_wv) chk(r1_mask == '0, "R7 mask off", 64'(r1_mask), 64'd0);
      if (cmd_valid) begin
        chk(!full_prev, "R8 cmd after full", 64'(cmd_valid), 64'd0);
        chk(beats_seen == BEATS, "R5 beats before cmd", 64'(beats_seen), 64'(BEATS));
        if (qa.size() == 0) chk(1'b0, "R1 unexpected cmd", 64'(cmd_addr), 64'd0);
        else begin
          logic [30:0] ea;
          ea = qa.pop_front();
          chk(cmd_addr == ea, "R1 packed addr", 64'(cmd_addr), 64'(ea));
        end
        chk((cmd_addr >> USED) == 31'd0, "R2 upper bits", 64'(cmd_addr), 64'd0);
        beats_seen = 0;
        busy = 1'b0;
      end else if (busy) begin
        chk(!req_ready, "R9 ready while busy", 64'(req_ready), 64'd0);
      end
      afull_prev = ($urandom_range(99) < stall_pct);
      full_prev  = ($urandom_range(99) < stall_pct);
      wd_afull = afull_prev;
      cmd_full = full_prev;
    end
  end

  task automatic send(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c,
                      input logic [BL*DQ_W-1:0] d, input logic [BL*DQ_W/8-1:0] be);
    int to = 0;
    bit al;
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c; req_data = d; req_be = be;
    while (!req_ready && to < 5000) begin @(negedge clk); to++; end
    if (to >= 5000) chk(1'b0, "R9 ready never returned", 64'd0, 64'd1);
    @(posedge clk);
    al = (c[ALIGN-1:0] == '0);
    if (al) begin
      for (int k = 0; k < BEATS; k++) begin
        qd.push_back(d[k*WDW +: WDW]);
        qm.push_back(~be[k*BYTES +: BYTES]);
      end
      qa.push_back(pack(b, r, c));
      busy = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (!al) begin
      chk(req_err == 1'b1, "R3 error pulse", 64'(req_err), 64'd1);
      chk(req_ready == 1'b1, "R3 ready kept", 64'(req_ready), 64'd1);
      @(negedge clk);
      chk(req_err == 1'b0, "R3 pulse one cycle", 64'(req_err), 64'd0);
    end else begin
      chk(req_err == 1'b0, "R3 no error when aligned", 64'(req_err), 64'd0);
    end
  endtask

  task automatic drain();
    int to = 0;
    while ((busy || qd.size() != 0) && to < 5000) begin @(negedge clk); to++; end
    chk(!busy && qd.size() == 0 && qa.size() == 0, "R4 drain", 64'(qd.size()), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4*150000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready in reset", 64'(req_ready), 64'd1);
    chk(!wd_valid && !cmd_valid && !req_err, "R10 outputs idle", 64'({wd_valid, cmd_valid, req_err}), 64'd0);
    rst = 1'b0;

    // directed corners, no stalls
    stall_pct = 0;
    send('1, '1, {COL_W{1'b1}} << ALIGN, 64'h0123_4567_89ab_cdef, 8'hff);
    send('0, '0, '0, 64'hdead_beef_cafe_f00d, 8'h00);
    send(2'd1, 13'h0aaa, 10'h154, 64'h1111_2222_3333_4444, 8'ha5);
    send(2'd2, 13'h1555, 10'h001, 64'h5, 8'h0f);   // misaligned
    send(2'd3, 13'h0001, 10'h002, 64'h6, 8'h0f);   // misaligned
    send(2'd3, 13'h0001, 10'h3ff, 64'h7, 8'h0f);   // misaligned
    drain();

    // heavy backpressure
    stall_pct = 90;
    for (int i = 0; i < 6; i++)
      send(BANK_W'($urandom), ROW_W'($urandom), COL_W'($urandom) & ~COL_W'(BL-1),
           {$urandom, $urandom}, 8'($urandom));
    drain();

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [COL_W-1:0] c;
      stall_pct = $urandom_range(60);
      c = COL_W'($urandom);
      if ($urandom_range(3) != 0) c = c & ~COL_W'(BL-1);
      send(BANK_W'($urandom), ROW_W'($urandom), c, {$urandom, $urandom}, 8'($urandom));
    end
    drain();
    stall_pct = 0;
    repeat (10) @(negedge clk);
    chk(qd.size() == 0 && qa.size() == 0, "R4 nothing left", 64'(qa.size()), 64'd0);
    finish_run();
  end
endmodule